// File: doc/BRIEF.md
# Triggered Delay-Then-Width Pulse Channel

This block turns one rising edge on an asynchronous trigger line into a single output pulse. The pulse begins a programmed number of clock periods after the trigger and stays high for a second programmed number of clock periods. Two counter stages are chained. The first stage times the delay, and its expiry starts the second stage, which times the width. Only the start of the delay inherits the one-period uncertainty of the asynchronous trigger. The width is produced entirely inside the clock domain, so its length is exact.

Each stage counts up from zero and compares the count against a target. The compare is split into registered levels so that it stays fast: small bit groups are matched first, then the group matches are combined. The target is the programmed length minus the compare latency, so a programmed value of N gives exactly N clock periods. Settings are written through a simple write port into holding registers. They are copied into the working registers only when a trigger is accepted. Several channels can be placed side by side, one instance per channel.

Top module: `dly_pulse_chan`

## Requirements
- R1: A low-to-high change of `trig_in` is passed through a two-flop synchronizer and an edge detector. If `trig_in` is first high at clock edge k, the pulse rises after clock edge k+2+D, where D is the effective delay. A bench that samples once per cycle sees the pulse high in the (D+3)th sample after raising the trigger.
- R2: For a delay setting D of 2 or more, the pulse begins exactly D clock periods after the accepting edge. Settings are selected by `cfg_sel`: 0 writes the delay and 1 writes the width, with the value taken from `cfg_data` while `cfg_we` is high.
- R3: For a width setting W of 2 or more, `pulse_out` is high for exactly W consecutive clock periods. This holds whatever the trigger phase is.
- R4: A delay setting of 0 or 1 is treated as 2.
- R5: A width setting of 1 is treated as 2.
- R6: A width setting of 0 produces no pulse. The delay interval still runs, and the channel accepts a new trigger once it ends.
- R7: A trigger edge that arrives during a delay or width interval is ignored. It neither restarts the interval nor produces a second pulse.
- R8: A settings write during an interval does not change that interval. The new values apply from the next accepted trigger.
- R9: After reset, `pulse_out` is low and both holding registers are 0. A trigger then runs a delay of 2 and produces no pulse.
- R10: A trigger held high produces only one pulse. A new pulse needs the line to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| trig_in | input | 1 | Asynchronous trigger line |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 1 | Setting select: 0 = delay, 1 = width |
| cfg_data | input | 13 | Setting value in clock periods |
| pulse_out | output | 1 | Output pulse |

## Verification
The bench checks the compare offset. A design that forgot to subtract the pipeline latency would stretch every delay and width by two periods. The values most likely to break the clamp and the compare groups are the small settings 0, 1 and 2 and the largest 13-bit value. A clamp error would show up as a pulse that is too short or missing, and a group-slicing error would make the largest value misfire.

Trigger edges are placed inside the delay and inside the width to catch a channel that restarts or emits a second pulse. Settings are rewritten in the middle of an interval to catch a design that reads the holding registers directly instead of the latched copy. A zero width must yield no pulse, yet the channel must re-arm afterwards.

// File: rtl/chan_pkg.sv
package chan_pkg;
  // Number of clocks between the counter value and the registered match,
  // also the smallest interval the compare pipeline can time.
  localparam int unsigned PIPE_LAT = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_WIDTH = 2'd2
  } chan_st_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned CW = 13,
  parameter int unsigned GW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          fin
);
  localparam int unsigned NG = (CW + GW - 1) / GW;
  localparam logic [CW-1:0] LAT_V = CW'(chan_pkg::PIPE_LAT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic [NG-1:0] eq_q, eq_d, eq_c;
  logic [CW-1:0] tgt;

  // Target pre-compensated for the two-level compare latency.
  assign tgt = len - LAT_V;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int unsigned LO = g * GW;
    localparam int unsigned HI = ((LO + GW) > CW) ? (CW - 1) : (LO + GW - 1);
    assign eq_c[g] = (cnt_q[HI:LO] == tgt[HI:LO]);
  end

  assign fin = run_q & (&eq_q);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    eq_d  = eq_c;
    if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
      eq_d  = '0;
    end else begin
      if (run_q) cnt_d = cnt_q + 1'b1;
      if (fin)   run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      eq_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      eq_q  <= eq_d;
    end
  end
endmodule

// File: rtl/dly_pulse_chan.sv
module dly_pulse_chan #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  output logic             pulse_out
);
  import chan_pkg::*;

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(PIPE_LAT);

  logic             trig_edge;
  logic             accept;
  logic             dly_fin, wid_fin, wid_start;
  logic [CNT_W-1:0] dly_sh_q, wid_sh_q;
  logic [CNT_W-1:0] act_dly, act_wid;
  logic [CNT_W-1:0] dly_cl, wid_cl;
  chan_st_e         st_q, st_d;

  trig_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(trig_edge)
  );

  assign accept    = (st_q == ST_IDLE) & trig_edge;
  assign wid_start = (st_q == ST_DELAY) & dly_fin & (act_wid != '0);

  oneshot_timer #(.CW(CNT_W), .GW(GRP_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .start(accept), .len(act_dly), .fin(dly_fin)
  );

  oneshot_timer #(.CW(CNT_W), .GW(GRP_W)) u_wid (
    .clk(clk), .rst_n(rst_n), .start(wid_start), .len(act_wid), .fin(wid_fin)
  );

  // Clamp settings to what the compare pipeline can time.
  always_comb begin
    dly_cl = (dly_sh_q < MIN_V) ? MIN_V : dly_sh_q;
    if (wid_sh_q == '0)       wid_cl = '0;
    else if (wid_sh_q < MIN_V) wid_cl = MIN_V;
    else                       wid_cl = wid_sh_q;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_DELAY;
      ST_DELAY: if (dly_fin) st_d = (act_wid == '0) ? ST_IDLE : ST_WIDTH;
      ST_WIDTH: if (wid_fin) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_sh_q <= '0;
      wid_sh_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) wid_sh_q <= cfg_data;
      else         dly_sh_q <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dly <= MIN_V;
      act_wid <= '0;
    end else if (accept) begin
      act_dly <= dly_cl;
      act_wid <= wid_cl;
    end
  end

  assign pulse_out = (st_q == ST_WIDTH);
endmodule

// File: rtl/dly_pulse_chan_chk.sv
module dly_pulse_chan_chk #(
  parameter int unsigned CW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_out,
  input logic              dly_fin,
  input logic              wid_fin,
  input chan_pkg::chan_st_e st_q,
  input logic [CW-1:0]     act_dly,
  input logic [CW-1:0]     act_wid
);
  import chan_pkg::*;

  // R3: the two stages never finish in the same cycle
  p_fin_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dly_fin, wid_fin}));

  // R7 / R8: latched settings hold while an interval runs
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(act_dly) && $stable(act_wid)));

  // R5: every pulse lasts at least two periods
  p_min_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> $past(pulse_out, 2));

  // R2: a pulse starts only right after the delay stage finishes
  p_rise_after_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(dly_fin));

  // R4: a running delay is never shorter than the pipeline minimum
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY) |-> (act_dly >= CW'(PIPE_LAT)));

  // R6: zero width gives no pulse after the delay
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_fin && (act_wid == '0)) |=> !pulse_out);
endmodule

bind dly_pulse_chan dly_pulse_chan_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .dly_fin(dly_fin),
  .wid_fin(wid_fin), .st_q(st_q), .act_dly(act_dly), .act_wid(act_wid)
);

// File: tb/dly_pulse_chan_bench.sv
`timescale 1ns/1ps
module dly_pulse_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [12:0] cfg_data = '0;
  logic        pulse_out;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  dly_pulse_chan u_dly_pulse_chan (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pulse_out(pulse_out)
  );

  always #10 clk = ~clk;

  function automatic int exp_rise(input int d);
    return ((d < 2) ? 2 : d) + 3;
  endfunction

  function automatic int exp_wid(input int w);
    if (w == 0) return 0;
    return (w < 2) ? 2 : w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = 13'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Raise trigger, report first sample with pulse high (-1 if none) and width.
  task automatic shot(input int d, output int rise, output int wid);
    int lim;
    lim = exp_rise(d) + 40;
    rise = -1; wid = 0;
    @(negedge clk);
    trig_in = 1'b1;
    for (int n = 1; n <= lim; n++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out) begin rise = n; break; end
    end
    if (rise > 0) begin
      while (pulse_out && wid < 9000) begin
        wid++;
        @(posedge clk); @(negedge clk);
      end
    end
    trig_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_case(input int d, input int w, input string tag);
    int r, wd;
    wr(1'b0, d);
    wr(1'b1, w);
    shot(d, r, wd);
    if (exp_wid(w) == 0) begin
      chk(r == -1, {tag, " R6 no pulse"}, r, -1);
    end else begin
      chk(r == exp_rise(d), {tag, " R1 R2 R4 rise"}, r, exp_rise(d));
      chk(wd == exp_wid(w), {tag, " R3 R5 width"}, wd, exp_wid(w));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r, wd, rises, high;
    bit prev;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R9 reset pulse low", int'(pulse_out), 0);

    // R9: reset settings -> delay 2, width 0, no pulse
    shot(0, r, wd);
    chk(r == -1, "R9 default no pulse", r, -1);

    // Directed corners
    run_case(0, 1, "R4 R5 d0w1");
    run_case(1, 2, "R4 d1w2");
    run_case(2, 2, "R2 d2w2");
    run_case(7, 0, "R6 d7w0");
    run_case(3, 4, "R6 rearm");
    run_case(8191, 8191, "R2 R3 max");

    // R8: rewrite in mid-interval
    wr(1'b0, 30); wr(1'b1, 15);
    r = -1; wd = 0;
    @(negedge clk); trig_in = 1'b1;
    for (int n = 1; n <= 100; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 10) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 13'd5; end
      if (n == 11) begin cfg_sel = 1'b1; cfg_data = 13'd3; end
      if (n == 12) cfg_we = 1'b0;
      if (pulse_out && r < 0) r = n;
      if (pulse_out) wd++;
    end
    trig_in = 1'b0; repeat (6) @(negedge clk);
    chk(r == 33, "R8 rise unchanged", r, 33);
    chk(wd == 15, "R8 width unchanged", wd, 15);
    shot(5, r, wd);
    chk(r == 8, "R8 new delay applied", r, 8);
    chk(wd == 3, "R8 new width applied", wd, 3);

    // R7: edges during delay and during width are ignored
    wr(1'b0, 20); wr(1'b1, 10);
    rises = 0; high = 0; prev = 1'b0;
    @(negedge clk); trig_in = 1'b1;
    for (int n = 1; n <= 80; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 15) trig_in = 1'b0;
      if (n == 18) trig_in = 1'b1;
      if (n == 25) trig_in = 1'b0;
      if (n == 27) trig_in = 1'b1;
      if (n == 30) trig_in = 1'b0;
      if (pulse_out && !prev) rises++;
      if (pulse_out) high++;
      prev = pulse_out;
    end
    chk(rises == 1, "R7 one pulse only", rises, 1);
    chk(high == 10, "R7 width kept", high, 10);

    // R10: held trigger does not repeat
    wr(1'b0, 4); wr(1'b1, 3);
    high = 0;
    @(negedge clk); trig_in = 1'b1;
    for (int n = 1; n <= 60; n++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out) high++;
    end
    trig_in = 1'b0; repeat (6) @(negedge clk);
    chk(high == 3, "R10 held trigger single pulse", high, 3);

    // Random settings and trigger phase
    for (int i = 0; i < 25; i++) begin
      int d, w, gap;
      d = $urandom_range(0, 200);
      w = $urandom_range(0, 120);
      gap = $urandom_range(0, 7);
      wr(1'b0, d); wr(1'b1, w);
      repeat (gap) @(negedge clk);
      #($urandom_range(1, 9));
      shot(d, r, wd);
      if (exp_wid(w) == 0) begin
        chk(r == -1, "R6 random zero width", r, -1);
      end else begin
        chk(r == exp_rise(d), "R1 R2 random rise", r, exp_rise(d));
        chk(wd == exp_wid(w), "R3 random width", wd, exp_wid(w));
      end
    end

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule